// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is the device side of a four-wire serial link (SPI mode 0, chip select active low) that gives a host access to a small file of 8-bit configuration registers. Each transfer starts with an address byte. Its most significant bit chooses the direction, and its low seven bits name the register. A write transfer carries one more byte with the new value. A read transfer makes the block shift the addressed register back to the host during the second byte.

The serial clock, chip select and data-in lines are brought into the system clock domain through a chain of synchronising flops. All register state changes on the system clock. Word zero is a read-only identification constant. Writes to that word, and reads or writes above the top of the file, have no effect. Clearing bit 0 of the reset word returns the whole file to its power-up values. Three of the registers drive dedicated outputs into the rest of the chip: supply/standby control, signal polarity, and regulator level.

Top module: `spicfg_target`

## Requirements
- R1: The first byte of a transfer is the address byte. Bit 7 = 0 marks a write and bit 7 = 1 marks a read. Bits 6..0 give the register address.
- R2: Bytes go most significant bit first and are sampled on rising SCK. A write changes state only when the 16th bit has been received. In a read, the register value appears on MISO over bits 9..16: each bit changes after a falling SCK edge, with bit 7 in place before the 9th rising edge.
- R3: Address 0x00 always reads 0x96, and a write to it changes nothing.
- R4: After reset the registers hold these values: 0x01=0x0F, 0x02=0x2E, 0x03=0x12, 0x04=0x01, 0x07=0xEF, 0x0A=0x09. Every other address from 0x05 to 0x44 holds 0x00.
- R5: A write to 0x04 with data bit 0 = 0 restores every register to its R4 value. This includes 0x04, which returns to 0x01.
- R6: A write to 0x04 with data bit 0 = 1 stores the value and resets nothing.
- R7: Addresses 0x01 through 0x44 are read/write. A read above 0x44 returns 0x00, and a write above 0x44 changes no register.
- R8: If chip select goes high before the 16th bit of a transfer, the transfer is dropped and no register changes.
- R9: `pwr_ctrl_o`, `pol_ctrl_o` and `vreg_ctrl_o` always show registers 0x07, 0x0A and 0x03.
- R10: MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial clock from the host (idles low) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| pwr_ctrl_o | output | 8 | Contents of register 0x07 |
| pol_ctrl_o | output | 8 | Contents of register 0x0A |
| vreg_ctrl_o | output | 8 | Contents of register 0x03 |

## Verification
The bench builds the block with its default parameters: two synchronising stages, 0x44 as the top address, and 0x96 as the identification value. With those values the last writable word (0x44) and the first unmapped one (0x45) are next to each other, so the boundary and aliasing behaviour of R7 can be tested directly. The host clock runs at twelve system cycles per SCK period. That leaves enough margin for the synchroniser delay, so every read byte can be compared bit for bit against the expected value pushed into the scoreboard.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

   localparam int BYTE_W     = 8;
   localparam int AW         = 7;
   localparam int FRAME_BITS = 2 * BYTE_W;

   localparam int A_VAMP = 1;
   localparam int A_VHI  = 2;
   localparam int A_VREG = 3;
   localparam int A_SRST = 4;
   localparam int A_PWR  = 7;
   localparam int A_POL  = 10;

   function automatic logic [BYTE_W-1:0] dflt(input int a);
      case (a)
         A_VAMP:  return 8'h0F;
         A_VHI:   return 8'h2E;
         A_VREG:  return 8'h12;
         A_SRST:  return 8'h01;
         A_PWR:   return 8'hEF;
         A_POL:   return 8'h09;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spicfg_frame.sv
module spicfg_frame
   import spicfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [AW-1:0]     addr,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_data,
   output logic              miso
);
   localparam int CW = $clog2(FRAME_BITS + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
   localparam logic [CW-1:0] CNT_ADDR = CW'(BYTE_W);

   logic              sck_d;
   logic              rise, fall;
   logic [CW-1:0]     bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic              is_rd;
   logic              load_tx;
   logic [BYTE_W-1:0] tx_sh;

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         is_rd   <= 1'b0;
         addr    <= '0;
         load_tx <= 1'b0;
         tx_sh   <= '0;
         wr_stb  <= 1'b0;
         wr_data <= '0;
         miso    <= 1'b0;
      end else if (cs_n_s) begin
         bit_cnt <= '0;
         load_tx <= 1'b0;
         tx_sh   <= '0;
         wr_stb  <= 1'b0;
         miso    <= 1'b0;
      end else begin
         wr_stb  <= 1'b0;
         load_tx <= 1'b0;
         if (load_tx) tx_sh <= is_rd ? rd_data : '0;
         if (rise && bit_cnt != CNT_FULL) begin
            rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_ADDR - 1'b1) begin
               is_rd   <= rx_sh[BYTE_W-2];
               addr    <= {rx_sh[BYTE_W-3:0], mosi_s};
               load_tx <= 1'b1;
            end
            if (bit_cnt == CNT_FULL - 1'b1 && !is_rd) begin
               wr_stb  <= 1'b1;
               wr_data <= {rx_sh, mosi_s};
            end
         end
         if (fall && bit_cnt >= CNT_ADDR) begin
            miso  <= tx_sh[BYTE_W-1];
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_FULL);
   assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0 && !wr_stb));
   assert_idle_miso_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !miso);
endmodule

// File: rtl/spicfg_regbank.sv
module spicfg_regbank
   import spicfg_pkg::*;
#(
   parameter int                ADDR_MAX = 'h44,
   parameter logic [BYTE_W-1:0] ID_VALUE = 8'h96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] pwr_o,
   output logic [BYTE_W-1:0] pol_o,
   output logic [BYTE_W-1:0] vreg_o
);
   localparam int NWORDS = 1 << AW;

   logic [BYTE_W-1:0] words [NWORDS];
   logic              srst;

   assign srst = wr_stb && addr == AW'(A_SRST) && !wr_data[0];

   for (genvar a = 0; a < NWORDS; a++) begin : g_word
      if (a == 0) begin : g_id
         assign words[a] = ID_VALUE;
      end else if (a <= ADDR_MAX) begin : g_rw
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= dflt(a);
            else if (srst)                      q <= dflt(a);
            else if (wr_stb && addr == AW'(a))  q <= wr_data;
         end
         assign words[a] = q;
      end else begin : g_hole
         assign words[a] = '0;
      end
   end

   assign rd_data = words[addr];
   assign pwr_o   = words[A_PWR];
   assign pol_o   = words[A_POL];
   assign vreg_o  = words[A_VREG];

   assert_srst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (pwr_o == dflt(A_PWR) && pol_o == dflt(A_POL) && vreg_o == dflt(A_VREG)));
   assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(pwr_o));
endmodule

// File: rtl/spicfg_target.sv
module spicfg_target
   import spicfg_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_MAX    = 'h44,
   parameter logic [BYTE_W-1:0] ID_VALUE    = 8'h96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [BYTE_W-1:0] pwr_ctrl_o,
   output logic [BYTE_W-1:0] pol_ctrl_o,
   output logic [BYTE_W-1:0] vreg_ctrl_o
);
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_MAX < A_POL || ADDR_MAX >= (1 << AW)) begin : g_chk_amax
      $error("ADDR_MAX must cover the control words and fit the address field");
   end

   logic [2:0]        pins_s;
   logic [AW-1:0]     addr;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_data;

   spicfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_cs_n, spi_mosi}),
      .q     (pins_s)
   );

   spicfg_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s   (pins_s[2]),
      .cs_n_s  (pins_s[1]),
      .mosi_s  (pins_s[0]),
      .rd_data (rd_data),
      .addr    (addr),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .miso    (spi_miso)
   );

   spicfg_regbank #(.ADDR_MAX(ADDR_MAX), .ID_VALUE(ID_VALUE)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pwr_o   (pwr_ctrl_o),
      .pol_o   (pol_ctrl_o),
      .vreg_o  (vreg_ctrl_o)
   );

   assert_id_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == '0) |=> ($stable(pwr_ctrl_o) && $stable(pol_ctrl_o)));
endmodule

// File: tb/spicfg_target_tb_top.sv
`timescale 1ns/1ps
module spicfg_target_tb_top;
   localparam int HALF  = 6;
   localparam int LIMIT = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       spi_miso;
   logic [7:0] pwr_ctrl_o, pol_ctrl_o, vreg_ctrl_o;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit done = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   spicfg_target dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .pwr_ctrl_o(pwr_ctrl_o),
      .pol_ctrl_o(pol_ctrl_o), .vreg_ctrl_o(vreg_ctrl_o)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_xfer(input logic [15:0] v, input int nbits);
      spi_cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = v[15-i];
         wait_clk(HALF);
         spi_sck = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b0;
      end
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      wait_clk(4 * HALF);
   endtask

   task automatic spi_write(input logic [6:0] a, input logic [7:0] d);
      spi_xfer({1'b0, a, d}, 16);
   endtask

   task automatic spi_read(input logic [6:0] a, input logic [7:0] exp, input string req);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      spi_xfer({1'b1, a, 8'h00}, 16);
   endtask

   // Monitor: rebuilds each frame from the pins and scores completed reads
   initial begin
      forever begin
         logic [15:0] mo, mi;
         int n;
         @(negedge spi_cs_n);
         mo = '0; mi = '0; n = 0;
         forever begin
            @(posedge spi_sck or posedge spi_cs_n);
            if (spi_cs_n) break;
            mo = {mo[14:0], spi_mosi};
            mi = {mi[14:0], spi_miso};
            n++;
         end
         if (n == 16 && mo[15]) begin
            if (exp_q.size() == 0) begin
               compared++; mismatched++;
               $display("FAIL R1: read frame with no expected item, got %02h expected none", mi[7:0]);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, mi[7:0], e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == LIMIT && !done) begin
         done = 1;
         compared++; mismatched++;
         $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, LIMIT);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R4 / R9 / R10 reset state at the ports
      chk("R4 pwr reset", pwr_ctrl_o, 8'hEF);
      chk("R4 pol reset", pol_ctrl_o, 8'h09);
      chk("R9 vreg reset", vreg_ctrl_o, 8'h12);
      chk("R10 idle miso", {7'd0, spi_miso}, 8'h00);

      // R1 / R3 / R4 defaults by read-back
      spi_read(7'h00, 8'h96, "R3 id read");
      spi_read(7'h01, 8'h0F, "R4 0x01");
      spi_read(7'h02, 8'h2E, "R4 0x02");
      spi_read(7'h03, 8'h12, "R4 0x03");
      spi_read(7'h04, 8'h01, "R4 0x04");
      spi_read(7'h05, 8'h00, "R4 0x05");
      spi_read(7'h07, 8'hEF, "R4 0x07");
      spi_read(7'h0A, 8'h09, "R4 0x0A");

      // R3 write to id ignored
      spi_write(7'h00, 8'h55);
      spi_read(7'h00, 8'h96, "R3 id after write");

      // R2 / R9 writes and control outputs
      spi_write(7'h07, 8'h3C);
      chk("R9 pwr follows", pwr_ctrl_o, 8'h3C);
      spi_read(7'h07, 8'h3C, "R2 readback 0x07");
      spi_write(7'h0A, 8'hA5);
      chk("R9 pol follows", pol_ctrl_o, 8'hA5);
      spi_write(7'h03, 8'h07);
      chk("R9 vreg follows", vreg_ctrl_o, 8'h07);
      spi_write(7'h12, 8'h80);
      spi_read(7'h12, 8'h80, "R2 msb first");
      spi_write(7'h13, 8'h01);
      spi_read(7'h13, 8'h01, "R2 lsb");

      // R7 boundary and unmapped space
      spi_write(7'h44, 8'h5A);
      spi_read(7'h44, 8'h5A, "R7 top word");
      spi_write(7'h45, 8'h77);
      spi_read(7'h45, 8'h00, "R7 above top");
      spi_read(7'h05, 8'h00, "R7 no alias");
      spi_write(7'h7F, 8'hFF);
      spi_read(7'h7F, 8'h00, "R7 highest code");

      // R8 aborted write frame
      spi_xfer({1'b0, 7'h07, 8'h81}, 12);
      chk("R8 abort pwr", pwr_ctrl_o, 8'h3C);
      spi_read(7'h07, 8'h3C, "R8 abort readback");

      // R6 reset word with bit0 set
      spi_write(7'h04, 8'h03);
      chk("R6 no reset pwr", pwr_ctrl_o, 8'h3C);
      spi_read(7'h04, 8'h03, "R6 stored");

      // R5 soft reset
      spi_write(7'h04, 8'h00);
      chk("R5 pwr", pwr_ctrl_o, 8'hEF);
      chk("R5 pol", pol_ctrl_o, 8'h09);
      chk("R5 vreg", vreg_ctrl_o, 8'h12);
      spi_read(7'h44, 8'h00, "R5 top word cleared");
      spi_read(7'h04, 8'h01, "R5 reset word");
      spi_read(7'h12, 8'h00, "R5 0x12 cleared");
      chk("R10 idle miso end", {7'd0, spi_miso}, 8'h00);

      wait_clk(10);
      if (exp_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL R2: got %0d unscored reads expected 0", exp_q.size());
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule